// File: doc/BRIEF.md
# SMBus Register Pointer Access Controller

This block sits behind the bit-level engine of an SMBus slave and turns its decoded byte events into accesses on a small internal address space. It keeps a 16-bit pointer. The pointer can reach three separate windows: a 128-entry register window at 0000h–007Fh, a 256-byte nonvolatile window at 8000h–80FFh and a 64-byte nonvolatile window at 8100h–813Fh. The block holds the register file and a byte-array model of the nonvolatile memory. It returns one data byte for each read request.

A write transaction carries the pointer as two bytes, high byte first, and then zero or more data bytes. A read transaction returns data from wherever the pointer already stands. To read a chosen location, the master writes only the pointer bytes and then issues a repeated-start read. When the engine flags a block operation, every access moves the pointer forward by one. The pointer stops at the last address of its window and does not roll over into the next window. Once a window is exhausted, reads return zero and writes are accepted but discarded, until a new pointer is written.

Top module: `smbus_ptr_access`

## Requirements
- R1: After reset the pointer is 0000h, the exhausted flag is 0, rd_valid is 0 and rd_data is 00h.
- R2: In a write transaction (ev_start with ev_is_read=0), the first written byte is the pointer high byte. The second is the pointer low byte: it loads the pointer and clears the exhausted flag. Every later byte is a data write at the pointer.
- R3: Each ev_rdreq during a read transaction (ev_start with ev_is_read=1) gives rd_valid=1 on the next cycle, with rd_data equal to the byte at the pointer in force when the request was made, including when no pointer write came before it.
- R4: With blk_mode=0, reads and data writes leave the pointer unchanged.
- R5: With blk_mode=1, each read or data write at a non-final address of its window, or outside every window, advances the pointer by one.
- R6: Register window: addresses 00h–1Bh are read/write and reset to 00h. 7Eh reads A5h and 7Fh reads 01h; writes to either are discarded. All other register addresses read 00h and discard writes.
- R7: A block access at 80FFh performs the access and then leaves the pointer at 80FFh with the exhausted flag set. It does not move to 8100h.
- R8: A block access at 813Fh performs the access and then leaves the pointer at 813Fh with the exhausted flag set. It does not move to 8140h.
- R9: While the exhausted flag is set, reads return 00h, data writes change no location, and the pointer is frozen.
- R10: Addresses outside all three windows read 00h and discard writes.
- R11: Every nonvolatile byte reads FFh after reset until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Address matched; starts or restarts a transaction |
| ev_is_read | input | 1 | Direction qualifier for ev_start (1 = read) |
| ev_wbyte | input | 1 | A byte was written by the master |
| ev_wdata | input | 8 | Value of the written byte |
| ev_rdreq | input | 1 | Engine requests the next byte to transmit |
| ev_stop | input | 1 | Stop condition; ends the transaction |
| blk_mode | input | 1 | Block operation in progress (auto-increment) |
| rd_data | output | 8 | Byte returned for the last read request |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a new byte |
| ptr_o | output | 16 | Current internal pointer |
| sat_o | output | 1 | Window-exhausted flag |

## Verification
On every cycle the assertions check how the pointer moves: a byte-mode access holds it, a block access below the window end steps it by one, a pointer load clears the exhausted flag, an exhausted pointer stays frozen, and an exhausted or out-of-window read returns zero one cycle later. Only the bench scenarios can show what the pointer stepping cannot: the contents of storage after writes. That includes data landing in the right window and the read-only and unused registers keeping their values. They also cover the erased state of the nonvolatile model and the exact stopping address at 80FFh and 813Fh as seen through later reads.

// File: rtl/smbus_ptr_pkg.sv
package smbus_ptr_pkg;
  typedef enum logic [1:0] {
    WIN_REG  = 2'd0,
    WIN_EE0  = 2'd1,
    WIN_EE1  = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PHI   = 3'd1,
    ST_PLO   = 3'd2,
    ST_WDATA = 3'd3,
    ST_READ  = 3'd4
  } txn_st_e;
endpackage

// File: rtl/smbus_reg_bank.sv
module smbus_reg_bank #(
  parameter int         AW      = 7,
  parameter int         RW_CNT  = 28,
  parameter logic [6:0] ID_ADDR = 7'h7E,
  parameter logic [7:0] ID_VAL  = 8'hA5,
  parameter logic [6:0] REV_ADDR = 7'h7F,
  parameter logic [7:0] REV_VAL  = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] regs [RW_CNT];

  for (genvar g = 0; g < RW_CNT; g++) begin : g_rw
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= 8'h00;
      else if (we && (int'(addr) == g))
        regs[g] <= wdata;
    end
  end

  always_comb begin
    if (int'(addr) < RW_CNT)
      rdata = regs[int'(addr)];
    else if (addr == ID_ADDR[AW-1:0])
      rdata = ID_VAL;
    else if (addr == REV_ADDR[AW-1:0])
      rdata = REV_VAL;
    else
      rdata = 8'h00;
  end
endmodule

// File: rtl/smbus_ee_model.sv
module smbus_ee_model #(
  parameter int         DEPTH  = 256,
  parameter logic [7:0] ERASED = 8'hFF,
  localparam int        AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/smbus_ptr_ctrl.sv
module smbus_ptr_ctrl
  import smbus_ptr_pkg::*;
#(
  parameter logic [15:0] REG_LAST = 16'h007F,
  parameter logic [15:0] EE0_BASE = 16'h8000,
  parameter logic [15:0] EE0_LAST = 16'h80FF,
  parameter logic [15:0] EE1_BASE = 16'h8100,
  parameter logic [15:0] EE1_LAST = 16'h813F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_start,
  input  logic        ev_is_read,
  input  logic        ev_wbyte,
  input  logic [7:0]  ev_wdata,
  input  logic        ev_rdreq,
  input  logic        ev_stop,
  input  logic        blk_mode,
  output logic [15:0] ptr_o,
  output logic        sat_o,
  output win_e        win_o,
  output logic        wr_en_o,
  output logic        rd_go_o
);
  function automatic win_e win_of(input logic [15:0] a);
    if (a <= REG_LAST)                      return WIN_REG;
    else if (a >= EE0_BASE && a <= EE0_LAST) return WIN_EE0;
    else if (a >= EE1_BASE && a <= EE1_LAST) return WIN_EE1;
    else                                     return WIN_NONE;
  endfunction

  function automatic logic [15:0] win_end(input win_e w);
    case (w)
      WIN_REG: return REG_LAST;
      WIN_EE0: return EE0_LAST;
      WIN_EE1: return EE1_LAST;
      default: return 16'hFFFF;
    endcase
  endfunction

  txn_st_e     st_q;
  logic [15:0] ptr_q;
  logic [7:0]  hi_q;
  logic        sat_q;

  // named internal events
  win_e cur_win;
  logic ptr_load, data_evt, rd_evt, acc, at_last;

  assign cur_win  = win_of(ptr_q);
  assign at_last  = (cur_win != WIN_NONE) && (ptr_q == win_end(cur_win));
  assign ptr_load = ev_wbyte && (st_q == ST_PLO);
  assign data_evt = ev_wbyte && (st_q == ST_WDATA);
  assign rd_evt   = ev_rdreq && (st_q == ST_READ);
  assign acc      = data_evt || rd_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      hi_q <= 8'h00;
    end else if (ev_stop) begin
      st_q <= ST_IDLE;
    end else if (ev_start) begin
      st_q <= ev_is_read ? ST_READ : ST_PHI;
    end else if (ev_wbyte) begin
      case (st_q)
        ST_PHI: begin hi_q <= ev_wdata; st_q <= ST_PLO; end
        ST_PLO: st_q <= ST_WDATA;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= 16'h0000;
      sat_q <= 1'b0;
    end else if (ptr_load) begin
      ptr_q <= {hi_q, ev_wdata};
      sat_q <= 1'b0;
    end else if (acc && blk_mode && !sat_q) begin
      if (at_last) sat_q <= 1'b1;
      else         ptr_q <= ptr_q + 16'd1;
    end
  end

  assign ptr_o   = ptr_q;
  assign sat_o   = sat_q;
  assign win_o   = cur_win;
  assign wr_en_o = data_evt && !sat_q && (cur_win != WIN_NONE);
  assign rd_go_o = rd_evt;

  // R4
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !blk_mode) |=> $stable(ptr_q));
  // R5
  blk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && blk_mode && !sat_q && !at_last) |=> (ptr_q == $past(ptr_q) + 16'd1));
  // R2
  load_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (!sat_q && ptr_q == {$past(hi_q), $past(ev_wdata)}));
  // R9
  sat_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !ptr_load) |=> ($stable(ptr_q) && sat_q));
endmodule

// File: rtl/smbus_ptr_access.sv
module smbus_ptr_access
  import smbus_ptr_pkg::*;
#(
  parameter logic [15:0] REG_LAST = 16'h007F,
  parameter logic [15:0] EE0_BASE = 16'h8000,
  parameter logic [15:0] EE0_LAST = 16'h80FF,
  parameter logic [15:0] EE1_BASE = 16'h8100,
  parameter logic [15:0] EE1_LAST = 16'h813F,
  parameter int          REG_RW_CNT = 28,
  parameter logic [7:0]  EE_ERASED  = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_start,
  input  logic        ev_is_read,
  input  logic        ev_wbyte,
  input  logic [7:0]  ev_wdata,
  input  logic        ev_rdreq,
  input  logic        ev_stop,
  input  logic        blk_mode,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic [15:0] ptr_o,
  output logic        sat_o
);
  localparam int RAW       = $clog2(int'(REG_LAST) + 1);
  localparam int EE0_DEPTH = int'(EE0_LAST - EE0_BASE) + 1;
  localparam int EE1_DEPTH = int'(EE1_LAST - EE1_BASE) + 1;
  localparam int AW0       = $clog2(EE0_DEPTH);
  localparam int AW1       = $clog2(EE1_DEPTH);

  win_e        win;
  logic        wr_en, rd_go;
  logic [15:0] off0, off1;
  logic [7:0]  reg_rd, ee0_rd, ee1_rd, rd_mux;

  smbus_ptr_ctrl #(
    .REG_LAST(REG_LAST), .EE0_BASE(EE0_BASE), .EE0_LAST(EE0_LAST),
    .EE1_BASE(EE1_BASE), .EE1_LAST(EE1_LAST)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_is_read(ev_is_read),
    .ev_wbyte(ev_wbyte), .ev_wdata(ev_wdata), .ev_rdreq(ev_rdreq),
    .ev_stop(ev_stop), .blk_mode(blk_mode), .ptr_o(ptr_o), .sat_o(sat_o),
    .win_o(win), .wr_en_o(wr_en), .rd_go_o(rd_go)
  );

  assign off0 = ptr_o - EE0_BASE;
  assign off1 = ptr_o - EE1_BASE;

  smbus_reg_bank #(.AW(RAW), .RW_CNT(REG_RW_CNT)) i_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en && win == WIN_REG),
    .addr(ptr_o[RAW-1:0]), .wdata(ev_wdata), .rdata(reg_rd)
  );

  smbus_ee_model #(.DEPTH(EE0_DEPTH), .ERASED(EE_ERASED)) i_ee0 (
    .clk(clk), .rst_n(rst_n), .we(wr_en && win == WIN_EE0),
    .addr(off0[AW0-1:0]), .wdata(ev_wdata), .rdata(ee0_rd)
  );

  smbus_ee_model #(.DEPTH(EE1_DEPTH), .ERASED(EE_ERASED)) i_ee1 (
    .clk(clk), .rst_n(rst_n), .we(wr_en && win == WIN_EE1),
    .addr(off1[AW1-1:0]), .wdata(ev_wdata), .rdata(ee1_rd)
  );

  always_comb begin
    case (win)
      WIN_REG: rd_mux = reg_rd;
      WIN_EE0: rd_mux = ee0_rd;
      WIN_EE1: rd_mux = ee1_rd;
      default: rd_mux = 8'h00;
    endcase
    if (sat_o) rd_mux = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_data <= rd_mux;
    end
  end

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_valid);
  // R9
  sat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && sat_o) |=> (rd_data == 8'h00));
  // R10
  nowin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && win == WIN_NONE) |=> (rd_data == 8'h00));
endmodule

// File: tb/test_smbus_ptr_access.sv
module test_smbus_ptr_access;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_start = 0, ev_is_read = 0, ev_wbyte = 0, ev_rdreq = 0, ev_stop = 0;
  logic        blk_mode = 0;
  logic [7:0]  ev_wdata = 8'h00;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [15:0] ptr_o;
  logic        sat_o;

  int n_cmp = 0, n_bad = 0;

  // bench model
  logic [7:0]  m_reg [28];
  logic [7:0]  m_ee0 [256];
  logic [7:0]  m_ee1 [64];
  logic [15:0] m_ptr;
  logic        m_sat;

  smbus_ptr_access i_smbus_ptr_access (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_is_read(ev_is_read),
    .ev_wbyte(ev_wbyte), .ev_wdata(ev_wdata), .ev_rdreq(ev_rdreq),
    .ev_stop(ev_stop), .blk_mode(blk_mode), .rd_data(rd_data),
    .rd_valid(rd_valid), .ptr_o(ptr_o), .sat_o(sat_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // region: 0 registers, 1 first nonvolatile, 2 second nonvolatile, 3 none
  function automatic int m_region(input logic [15:0] a);
    if (a < 16'h0080) return 0;
    if (a[15:8] == 8'h80) return 1;
    if (a >= 16'h8100 && a < 16'h8140) return 2;
    return 3;
  endfunction

  function automatic logic [15:0] m_limit(input int r);
    return (r == 0) ? 16'h007F : (r == 1) ? 16'h80FF : 16'h813F;
  endfunction

  function automatic logic [7:0] m_peek(input logic [15:0] a);
    case (m_region(a))
      0: begin
        if (a < 16'd28)      return m_reg[a[4:0]];
        if (a == 16'h007E)   return 8'hA5;
        if (a == 16'h007F)   return 8'h01;
        return 8'h00;
      end
      1: return m_ee0[a[7:0]];
      2: return m_ee1[a[5:0]];
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_advance();
    if (blk_mode && !m_sat) begin
      if (m_region(m_ptr) != 3 && m_ptr == m_limit(m_region(m_ptr))) m_sat = 1'b1;
      else m_ptr = m_ptr + 16'd1;
    end
  endtask

  task automatic m_write(input logic [7:0] d);
    if (!m_sat) begin
      case (m_region(m_ptr))
        0: if (m_ptr < 16'd28) m_reg[m_ptr[4:0]] = d;
        1: m_ee0[m_ptr[7:0]] = d;
        2: m_ee1[m_ptr[5:0]] = d;
        default: ;
      endcase
    end
    m_advance();
  endtask

  task automatic m_read(output logic [7:0] e);
    e = m_sat ? 8'h00 : m_peek(m_ptr);
    m_advance();
  endtask

  task automatic pulse_start(input logic rd);
    ev_start = 1; ev_is_read = rd; @(negedge clk); ev_start = 0; ev_is_read = 0;
  endtask

  task automatic pulse_stop();
    ev_stop = 1; @(negedge clk); ev_stop = 0;
  endtask

  task automatic put_byte(input logic [7:0] d);
    ev_wbyte = 1; ev_wdata = d; @(negedge clk); ev_wbyte = 0;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    pulse_start(1'b0);
    put_byte(a[15:8]);
    put_byte(a[7:0]);
    m_ptr = a; m_sat = 1'b0;
  endtask

  task automatic wr_txn(input string req, input logic [15:0] a, input int n, input logic blk,
                        input logic [7:0] seed_d, input logic rnd);
    blk_mode = blk;
    set_ptr(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = rnd ? 8'($urandom) : seed_d + 8'(i);
      put_byte(d);
      m_write(d);
    end
    pulse_stop();
    check({req, " ptr"}, ptr_o, m_ptr);
    check({req, " sat"}, {15'd0, sat_o}, {15'd0, m_sat});
  endtask

  task automatic rd_txn(input string req, input logic setp, input logic [15:0] a,
                        input int n, input logic blk);
    blk_mode = blk;
    if (setp) set_ptr(a);
    pulse_start(1'b1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      ev_rdreq = 1; @(negedge clk); ev_rdreq = 0;
      m_read(e);
      check({req, " rd_valid"}, {15'd0, rd_valid}, 16'd1);
      check({req, " rd_data"}, {8'd0, rd_data}, {8'd0, e});
    end
    pulse_stop();
    check({req, " ptr"}, ptr_o, m_ptr);
    check({req, " sat"}, {15'd0, sat_o}, {15'd0, m_sat});
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom % 6)
      0: return 16'($urandom % 32);
      1: return 16'h0070 + 16'($urandom % 16);
      2: return 16'h8000 + 16'($urandom % 256);
      3: return 16'h80F8 + 16'($urandom % 8);
      4: return 16'h8100 + 16'($urandom % 64);
      default: return ($urandom % 2) ? 16'h0080 + 16'($urandom % 128)
                                     : 16'h8140 + 16'($urandom % 16);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] sd;
    sd = $urandom(32'h1D5);
    for (int i = 0; i < 28; i++) m_reg[i] = 8'h00;
    for (int i = 0; i < 256; i++) m_ee0[i] = 8'hFF;
    for (int i = 0; i < 64; i++) m_ee1[i] = 8'hFF;
    m_ptr = 16'h0000; m_sat = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ptr", ptr_o, 16'h0000);
    check("R1 sat", {15'd0, sat_o}, 16'd0);
    check("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
    check("R1 rd_data", {8'd0, rd_data}, 16'd0);

    // R2 pointer load, R4 byte write holds pointer
    wr_txn("R2", 16'h0005, 1, 1'b0, 8'h3C, 1'b0);
    check("R4 ptr hold", ptr_o, 16'h0005);
    // R3 read at current pointer without pointer write
    rd_txn("R3", 1'b0, 16'h0000, 2, 1'b0);
    // R11 erased nonvolatile
    rd_txn("R11", 1'b1, 16'h8042, 1, 1'b0);
    rd_txn("R11", 1'b1, 16'h8120, 1, 1'b0);
    // R5 block write/read in register window
    wr_txn("R5", 16'h0010, 4, 1'b1, 8'h50, 1'b0);
    rd_txn("R5", 1'b1, 16'h0010, 4, 1'b1);
    // R6 read-only and unused registers
    rd_txn("R6", 1'b1, 16'h007E, 1, 1'b0);
    wr_txn("R6", 16'h007E, 1, 1'b0, 8'h11, 1'b0);
    rd_txn("R6", 1'b1, 16'h007E, 2, 1'b1);
    wr_txn("R6", 16'h0040, 1, 1'b0, 8'h77, 1'b0);
    rd_txn("R6", 1'b1, 16'h0040, 1, 1'b0);
    // R7 end of first window
    wr_txn("R7", 16'h80FD, 5, 1'b1, 8'hC0, 1'b0);
    check("R7 stop addr", ptr_o, 16'h80FF);
    check("R7 exhausted", {15'd0, sat_o}, 16'd1);
    rd_txn("R7", 1'b1, 16'h80FD, 5, 1'b1);
    rd_txn("R9", 1'b1, 16'h8100, 1, 1'b0);
    // R8 end of second window
    wr_txn("R8", 16'h813E, 4, 1'b1, 8'hE0, 1'b0);
    check("R8 stop addr", ptr_o, 16'h813F);
    rd_txn("R8", 1'b1, 16'h813E, 3, 1'b1);
    // R9 exhausted then byte read returns zero
    rd_txn("R9", 1'b0, 16'h0000, 2, 1'b0);
    rd_txn("R9", 1'b1, 16'h8140, 1, 1'b0);
    // R10 outside windows
    wr_txn("R10", 16'h2000, 2, 1'b1, 8'h99, 1'b0);
    rd_txn("R10", 1'b1, 16'h2000, 2, 1'b1);

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      int n;
      logic blk;
      a = pick_addr();
      n = 1 + int'($urandom % 5);
      blk = 1'($urandom % 2);
      if ($urandom % 2) wr_txn("R2 rnd", a, n, blk, 8'h00, 1'b1);
      else rd_txn("R3 rnd", ($urandom % 4) != 0, a, n, blk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule